// File: doc/BRIEF.md
# Optical Black Level Servo

This block holds the black level of a pixel stream at a programmable target. It takes one 12-bit pixel code per clock and a clamp-window strobe. The strobe marks the shielded optical-black pixels of each line, and its active level can be programmed. The corrected pixel is the input, minus a tracked black offset, plus the target level. The result is saturated to the code range and registered.

While the window is open and tracking is on, the block adds up the signed difference between each corrected pixel and the target. On the first pixel after the window closes, the mean of that difference is added to the offset with a gain of 1/8. The offset is kept in eighths of an LSB. The offset therefore moves once per line and settles where the black pixels come out exactly at the target. When tracking is switched off, the offset is frozen and the target is still added, so the target acts as a plain programmable pedestal.

Top module: `ob_servo`

## Requirements
- R1: A synchronous reset, while `rst` is high, clears `pix_out` and the offset to 0, sets the target level to 128 and makes the window strobe active low.
- R2: `pix_out` is sat(pix_in − floor(offset/8) + target), one clock after `pix_in`. The offset is a signed count in 1/8-LSB units, and the value subtracted is its integer part rounded toward minus infinity.
- R3: The corrected value saturates: a result below 0 gives 0, and a result above 4095 gives 4095.
- R4: A pixel is inside the window when `win_in` equals the programmed polarity bit (1 = active high, 0 = active low). Pixels outside the window never change the offset.
- R5: On the first pixel that is no longer in the window, the offset (in 1/8-LSB units) grows by the sum of (corrected pixel − target) over the window's pixels, divided by their count and truncated toward zero. That pixel still uses the old offset, and the new offset applies from the next pixel on.
- R6: While `track_off` is high, nothing is accumulated and the offset is held, but the target is still added to every pixel.
- R7: A clock with `cfg_we` high loads the target from `cfg_level` and the window polarity from `cfg_act_hi`. Both take effect from the next pixel.
- R8: A window only one pixel long still produces an update, using that single pixel's error.
- R9: With constant black pixels and repeated windows, the loop settles so that the black pixels come out exactly at the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_in | input | 12 | Raw pixel code |
| win_in | input | 1 | Clamp-window strobe, active level set by polarity |
| track_off | input | 1 | Freezes the offset when high |
| cfg_we | input | 1 | Loads target and polarity |
| cfg_level | input | 8 | New target black level |
| cfg_act_hi | input | 1 | New polarity, 1 = window active high |
| pix_out | output | 12 | Corrected, saturated pixel |

## Verification
A wrong offset shows at the ports as a shift of every later pixel. It appears on the second pixel after a window closes, so the bench compares every output cycle against a cycle-level model. A wrong window decode or a wrong accumulator shows only through the size of the next step, so directed single windows with known means check exact output codes. Long convergence runs expose wrong rounding, which would leave the black level a code or more away from the target.

// File: rtl/ob_servo.sv
module ob_servo #(
  parameter int PIX_W   = 12,
  parameter int TGT_W   = 8,
  parameter int FRAC    = 3,
  parameter int CNT_W   = 16,
  parameter int TGT_RST = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PIX_W-1:0] pix_in,
  input  logic             win_in,
  input  logic             track_off,
  input  logic             cfg_we,
  input  logic [TGT_W-1:0] cfg_level,
  input  logic             cfg_act_hi,
  output logic [PIX_W-1:0] pix_out
);
  localparam int OFF_W  = PIX_W + 1 + FRAC;
  localparam int CALC_W = PIX_W + 3;
  localparam int SUM_W  = PIX_W + 2 + CNT_W;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic signed [CALC_W-1:0] PIX_TOP = CALC_W'((1 << PIX_W) - 1);
  localparam logic signed [SUM_W-1:0] OFF_HI = SUM_W'((1 << (OFF_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] OFF_LO = -OFF_HI - SUM_W'(1);

  logic [TGT_W-1:0]        level_q;
  logic                    act_hi_q;
  logic                    win_q;
  logic signed [OFF_W-1:0] off_q;
  logic signed [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0]        cnt_q;

  logic                     win_now;
  logic signed [CALC_W-1:0] off_int, raw, err;
  logic [PIX_W-1:0]         pix_sat;
  logic signed [SUM_W-1:0]  mean, off_sum;
  logic signed [OFF_W-1:0]  off_next;
  logic                     win_end;

  assign win_now = ~(win_in ^ act_hi_q);
  assign win_end = win_q & ~win_now & ~track_off & (cnt_q != '0);
  assign off_int = CALC_W'(off_q >>> FRAC);
  assign raw     = $signed({3'b000, pix_in}) - off_int
                 + $signed({{(CALC_W-TGT_W){1'b0}}, level_q});
  assign pix_sat = (raw < 0) ? '0 : ((raw > PIX_TOP) ? '1 : raw[PIX_W-1:0]);
  assign err     = $signed({3'b000, pix_sat}) - $signed({{(CALC_W-TGT_W){1'b0}}, level_q});
  assign mean    = sum_q / $signed(SUM_W'(cnt_q));
  assign off_sum = SUM_W'(off_q) + mean;
  assign off_next = (off_sum > OFF_HI) ? OFF_W'(OFF_HI) :
                    ((off_sum < OFF_LO) ? OFF_W'(OFF_LO) : OFF_W'(off_sum));

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q  <= TGT_W'(TGT_RST);
      act_hi_q <= 1'b0;
      win_q    <= 1'b0;
      off_q    <= '0;
      sum_q    <= '0;
      cnt_q    <= '0;
      pix_out  <= '0;
    end else begin
      pix_out <= pix_sat;
      win_q   <= win_now;
      if (cfg_we) begin
        level_q  <= cfg_level;
        act_hi_q <= cfg_act_hi;
      end
      if (win_now && !track_off) begin
        if (cnt_q != CNT_MAX) begin
          sum_q <= sum_q + SUM_W'(err);
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        sum_q <= '0;
        cnt_q <= '0;
        if (win_end) off_q <= off_next;
      end
    end
  end
endmodule

module ob_servo_chk #(
  parameter int PIX_W   = 12,
  parameter int TGT_W   = 8,
  parameter int OFF_W   = 16,
  parameter int CNT_W   = 16,
  parameter int TGT_RST = 128
) (
  input logic                    clk,
  input logic                    rst,
  input logic [PIX_W-1:0]        pix_in,
  input logic                    track_off,
  input logic                    cfg_we,
  input logic [TGT_W-1:0]        cfg_level,
  input logic [PIX_W-1:0]        pix_out,
  input logic                    win_q,
  input logic                    win_now,
  input logic signed [OFF_W-1:0] off_q,
  input logic [TGT_W-1:0]        level_q,
  input logic [CNT_W-1:0]        cnt_q
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (pix_out == '0 && off_q == '0 && level_q == TGT_W'(TGT_RST)));

  // R5
  off_move_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(off_q) |-> $past(win_q && !win_now));

  // R6
  frozen_chk: assert property (@(posedge clk) disable iff (rst)
    track_off |=> ($stable(off_q) && cnt_q == '0));

  // R7
  cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> level_q == $past(cfg_level));

  // R3
  top_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_in == '1 && off_q <= 0) |=> pix_out == '1);

  // R4
  idle_cnt_chk: assert property (@(posedge clk) disable iff (rst)
    !win_q |-> cnt_q == '0);
endmodule

bind ob_servo ob_servo_chk #(
  .PIX_W(PIX_W), .TGT_W(TGT_W), .OFF_W(OFF_W), .CNT_W(CNT_W), .TGT_RST(TGT_RST)
) chk_i (
  .clk(clk), .rst(rst), .pix_in(pix_in), .track_off(track_off), .cfg_we(cfg_we),
  .cfg_level(cfg_level), .pix_out(pix_out), .win_q(win_q), .win_now(win_now),
  .off_q(off_q), .level_q(level_q), .cnt_q(cnt_q)
);

// File: tb/ob_servo_test.sv
module ob_servo_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] pix_in;
  logic        win_in, track_off, cfg_we, cfg_act_hi;
  logic [7:0]  cfg_level;
  logic [11:0] pix_out;

  always #5 clk = ~clk;

  ob_servo uut (
    .clk(clk), .rst(rst), .pix_in(pix_in), .win_in(win_in), .track_off(track_off),
    .cfg_we(cfg_we), .cfg_level(cfg_level), .cfg_act_hi(cfg_act_hi), .pix_out(pix_out)
  );

  int     n_run = 0, n_fail = 0;
  bit     done = 0;
  string  tag = "R1";
  longint m_off, m_sum;
  int     m_cnt, m_lvl, exp_out;
  bit     m_winq, m_hi;

  function automatic int fl8(longint v);
    return (v >= 0) ? int'(v / 8) : -int'((-v + 7) / 8);
  endfunction

  function automatic int sat12(longint v);
    return (v < 0) ? 0 : ((v > 4095) ? 4095 : int'(v));
  endfunction

  task automatic chk(string r, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic model_edge();
    int  y;
    bit  act;
    longint nxt;
    if (rst) begin
      m_off = 0; m_sum = 0; m_cnt = 0; m_lvl = 128; m_hi = 0; m_winq = 0; exp_out = 0;
      return;
    end
    y = sat12(longint'(pix_in) - fl8(m_off) + m_lvl);
    exp_out = y;
    act = m_hi ? win_in : !win_in;
    if (act && !track_off) begin
      if (m_cnt != 65535) begin
        m_sum += y - m_lvl;
        m_cnt++;
      end
    end else begin
      if (m_winq && !act && !track_off && m_cnt != 0) begin
        nxt = m_off + m_sum / m_cnt;
        m_off = (nxt > 32767) ? 32767 : ((nxt < -32768) ? -32768 : nxt);
      end
      m_sum = 0; m_cnt = 0;
    end
    if (cfg_we) begin
      m_lvl = cfg_level;
      m_hi = cfg_act_hi;
    end
    m_winq = act;
  endtask

  task automatic cyc(int x, bit s);
    pix_in = 12'(x);
    win_in = s;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    cfg_we = 1'b0;
    chk(tag, int'(pix_out), exp_out);
  endtask

  task automatic cfg(int lvl, bit hi, bit s);
    cfg_level = 8'(lvl);
    cfg_act_hi = hi;
    cfg_we = 1'b1;
    cyc(0, s);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4217));
    rst = 1'b1; pix_in = '0; win_in = 1'b1; track_off = 1'b1;
    cfg_we = 1'b0; cfg_level = '0; cfg_act_hi = 1'b0;
    @(negedge clk);
    tag = "R1";
    repeat (4) cyc(0, 1'b1);
    chk("R1", int'(pix_out), 0);
    rst = 1'b0;
    cyc(100, 1'b1);
    cyc(100, 1'b1);
    chk("R1", int'(pix_out), 228);

    tag = "R2";
    for (int i = 0; i < 200; i++) cyc(int'($urandom_range(0, 4095)), 1'b1);

    tag = "R7";
    cfg(128, 1'b1, 1'b1);
    track_off = 1'b0;
    cyc(0, 1'b0);
    cyc(300, 1'b0);
    chk("R7", int'(pix_out), 428);

    tag = "R5";
    for (int i = 0; i < 8; i++) cyc(300, 1'b1);
    cyc(300, 1'b0);
    chk("R5", int'(pix_out), 428);
    cyc(300, 1'b0);
    chk("R5", int'(pix_out), 391);

    tag = "R8";
    cyc(80 + 37 - 128 + 128, 1'b1);
    cyc(300, 1'b0);
    cyc(300, 1'b0);
    chk("R8", int'(pix_out), 300 - fl8(300 + 80) + 128);

    tag = "R4";
    for (int i = 0; i < 20; i++) cyc(int'($urandom_range(0, 4095)), 1'b0);
    cyc(300, 1'b0);
    cyc(300, 1'b0);
    chk("R4", int'(pix_out), 381);

    tag = "R3";
    cfg(0, 1'b1, 1'b0);
    cyc(10, 1'b0);
    cyc(10, 1'b0);
    chk("R3", int'(pix_out), 0);
    cfg(255, 1'b1, 1'b0);
    cyc(4095, 1'b0);
    cyc(4095, 1'b0);
    chk("R3", int'(pix_out), 4095);

    tag = "R6";
    track_off = 1'b1;
    cfg(200, 1'b1, 1'b0);
    for (int i = 0; i < 10; i++) cyc(4000, 1'b1);
    cyc(300, 1'b0);
    cyc(300, 1'b0);
    chk("R6", int'(pix_out), 300 - 47 + 200);
    track_off = 1'b0;

    tag = "R9";
    cfg(128, 1'b1, 1'b0);
    for (int w = 0; w < 150; w++) begin
      for (int i = 0; i < 24; i++) cyc(500, 1'b1);
      for (int i = 0; i < 8; i++) cyc(int'($urandom_range(0, 4095)), 1'b0);
    end
    cyc(500, 1'b0);
    cyc(500, 1'b0);
    chk("R9", int'(pix_out), 128);

    tag = "R4";
    cfg(90, 1'b0, 1'b1);
    for (int w = 0; w < 40; w++) begin
      for (int i = 0; i < 5; i++) cyc(700, 1'b0);
      for (int i = 0; i < 6; i++) cyc(int'($urandom_range(0, 4095)), 1'b1);
    end

    tag = "R2";
    for (int i = 0; i < 3000; i++) begin
      track_off = ($urandom_range(0, 15) == 0);
      if ($urandom_range(0, 200) == 0) begin
        cfg_level = 8'($urandom_range(0, 255));
        cfg_act_hi = 1'($urandom_range(0, 1));
        cfg_we = 1'b1;
      end
      cyc(int'($urandom_range(0, 4095)), 1'($urandom_range(0, 1)));
    end
    track_off = 1'b0;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule